// File: doc/BRIEF.md
# Edge Timestamp Ring Buffer with Interrupt Coalescing

The block gathers edge timestamps from five input channels and keeps the most recent 256 of them in a circular store. Each stored record combines a coarse time, a fine time, the channel that produced it and whether the edge was rising or falling. Writing never waits. When the store is full, each new record replaces the oldest one, and one record can be taken on every clock.

A host reaches the block through a small synchronous register port. It sets the channel enable mask and the two interrupt limits. It reads back the write pointer and the pending count. It selects a slot by index and reads that record as two 32-bit words.

The host is told of new data through one interrupt line, which combines two sources:
- a record-count threshold;
- a time limit counted from the first record not yet acknowledged.

Writing the acknowledge register starts a new batch.

Top module: `ts_ring_irq`

## Requirements
- R1: Channel codes 0 to 4 are valid. A valid event on channel code 5, 6 or 7 is dropped and changes neither the write pointer nor the pending count.
- R2: Each record stores its coarse time in full. It also stores fine time, channel and edge flag, read back from register 8 as bits [11:0], [14:12] and [15] (1 = rising). Both polarities are stored as separate records.
- R3: Accepted records go to slot `wr_ptr` of a 256-entry store, after which `wr_ptr` increments and wraps from 255 to 0. A full store is overwritten oldest-first, so after N accepted records each slot holds the latest record written to it.
- R4: With a nonzero threshold in register 1, `irq` rises on the clock edge after the pending count reaches the threshold.
- R5: With a nonzero time limit T in register 2, if the first pending record is accepted at edge E and no acknowledge follows, `irq` rises at edge E+T+1.
- R6: Bits [4:0] of register 0 enable channels 0 to 4, and all are set at reset. Events on a disabled channel are not stored and not counted.
- R7: A valid event on an enabled channel held on consecutive clocks is accepted on every clock.
- R8: Any write to register 3 clears `irq`, the pending count, the timer and the cause bits on that edge. A record accepted on the same edge leaves the pending count at 1.
- R9: The overflow flag sets when a record arrives while 256 are already pending. It stays set until reset. The pending count saturates at 256.
- R10: A threshold of 0 disables the count source, and a time limit of 0 disables the time source. The default for both is 0.
- R11: Register 4 bit 10 (count) and bit 11 (time) record which source raised `irq`. Both bits are set if the two sources fired on the same edge, and later hits do not change them until the next acknowledge.
- R12: Register 4 holds `wr_ptr` in [7:0], overflow in [8] and `irq` in [9], and register 5 holds the pending count. Writing a slot number to register 6 selects a record, whose coarse time is read from register 7. `reg_rdata` shows the register addressed on the previous edge, and record data is valid two edges after the index write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Timestamp event present this cycle |
| evt_chan | input | 3 | Channel code of the event |
| evt_edge | input | 1 | Edge polarity, 1 = rising |
| evt_coarse | input | 32 | Coarse time of the event |
| evt_fine | input | 12 | Fine time of the event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, held until acknowledge |

## Verification
The assertions assume that the host never writes register 3 while it expects an interrupt to rise: the acknowledge has priority over both sources, and the firing checks exclude that cycle. They also assume that the store depth is a power of two, so that the pointer wraps by overflow. The stimulus changes the limits only when the pending count is zero or unimportant, and it acknowledges before each interrupt scenario. It writes the acknowledge together with a record only in the one test that targets that case.

// File: rtl/ts_ring_pkg.sv
package ts_ring_pkg;
  localparam int NUM_CH   = 5;
  localparam int CHAN_W   = 3;
  localparam int COARSE_W = 32;
  localparam int FINE_W   = 12;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;

  typedef struct packed {
    logic                edge_rise;
    logic [CHAN_W-1:0]   chan;
    logic [FINE_W-1:0]   fine;
    logic [COARSE_W-1:0] coarse;
  } ts_rec_t;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_THRESH = 4'd1;
  localparam logic [ADDR_W-1:0] A_TLIMIT = 4'd2;
  localparam logic [ADDR_W-1:0] A_ACK    = 4'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd4;
  localparam logic [ADDR_W-1:0] A_PEND   = 4'd5;
  localparam logic [ADDR_W-1:0] A_INDEX  = 4'd6;
  localparam logic [ADDR_W-1:0] A_REC_LO = 4'd7;
  localparam logic [ADDR_W-1:0] A_REC_HI = 4'd8;

  localparam int ST_OVF  = 8;
  localparam int ST_IRQ  = 9;
  localparam int ST_CCNT = 10;
  localparam int ST_CTIM = 11;
endpackage

// File: rtl/ts_ring_store.sv
module ts_ring_store
  import ts_ring_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  ts_rec_t       wr_rec,
  input  logic [AW-1:0] rd_idx,
  output ts_rec_t       rd_rec,
  output logic [AW-1:0] wr_ptr
);
  ts_rec_t mem [DEPTH];

  // block-RAM style: write port, registered read port, no reset on array
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_rec;
  end

  always_ff @(posedge clk) begin
    rd_rec <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        wr_ptr <= '0;
    else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
  end

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wr_ptr));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));
endmodule

// File: rtl/ts_irq_ctrl.sv
module ts_irq_ctrl #(
  parameter int DEPTH = 256,
  parameter int TMR_W = 24,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_in,
  input  logic             ack,
  input  logic [PW-1:0]    thresh,
  input  logic [TMR_W-1:0] tlimit,
  output logic             irq,
  output logic [PW-1:0]    pending,
  output logic             overflow,
  output logic [1:0]       cause
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [TMR_W-1:0] timer;
  logic hit_cnt, hit_time;

  always_comb begin
    hit_cnt  = (thresh != '0) && (pending >= thresh);
    hit_time = (tlimit != '0) && (pending != '0) && (timer >= tlimit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= '0;
      timer    <= '0;
      irq      <= 1'b0;
      cause    <= 2'b00;
      overflow <= 1'b0;
    end else if (ack) begin
      pending <= rec_in ? PW'(1) : '0;
      timer   <= '0;
      irq     <= 1'b0;
      cause   <= 2'b00;
    end else begin
      if (rec_in) begin
        if (pending == FULL) overflow <= 1'b1;
        else                 pending  <= pending + 1'b1;
      end
      if (pending == '0)      timer <= '0;
      else if (timer != '1)   timer <= timer + 1'b1;
      irq <= irq | hit_cnt | hit_time;
      if (!irq) cause <= cause | {hit_time, hit_cnt};
    end
  end

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> (!irq && cause == 2'b00 && pending <= PW'(1)));

  assert_cnt_fire_R4: assert property (@(posedge clk) disable iff (rst)
    (!ack && thresh != '0 && pending >= thresh) |=> irq);

  assert_time_fire_R5: assert property (@(posedge clk) disable iff (rst)
    (!ack && tlimit != '0 && pending != '0 && timer >= tlimit) |=> irq);

  assert_irq_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pending != '0));

  assert_sources_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!irq && thresh == '0 && tlimit == '0) |=> !irq);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_pend_cap_R9: assert property (@(posedge clk) disable iff (rst)
    pending <= FULL);

  assert_cause_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> $stable(cause));
endmodule

// File: rtl/ts_host_regs.sv
module ts_host_regs
  import ts_ring_pkg::*;
#(
  parameter int AW    = 8,
  parameter int PW    = 9,
  parameter int TMR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [AW-1:0]     wr_ptr,
  input  logic [PW-1:0]     pending,
  input  logic              overflow,
  input  logic              irq,
  input  logic [1:0]        cause,
  input  ts_rec_t           rd_rec,
  output logic [NUM_CH-1:0] chan_en,
  output logic [PW-1:0]     thresh,
  output logic [TMR_W-1:0]  tlimit,
  output logic              ack,
  output logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [DATA_W-1:0] status_w, rd_mux;

  assign ack = reg_wr && (reg_addr == A_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en <= '1;
      thresh  <= '0;
      tlimit  <= '0;
      rd_idx  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:   chan_en <= reg_wdata[NUM_CH-1:0];
        A_THRESH: thresh  <= reg_wdata[PW-1:0];
        A_TLIMIT: tlimit  <= reg_wdata[TMR_W-1:0];
        A_INDEX:  rd_idx  <= reg_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    status_w          = DATA_W'(wr_ptr);
    status_w[ST_OVF]  = overflow;
    status_w[ST_IRQ]  = irq;
    status_w[ST_CCNT] = cause[0];
    status_w[ST_CTIM] = cause[1];
    case (reg_addr)
      A_CTRL:   rd_mux = DATA_W'(chan_en);
      A_THRESH: rd_mux = DATA_W'(thresh);
      A_TLIMIT: rd_mux = DATA_W'(tlimit);
      A_STATUS: rd_mux = status_w;
      A_PEND:   rd_mux = DATA_W'(pending);
      A_INDEX:  rd_mux = DATA_W'(rd_idx);
      A_REC_LO: rd_mux = rd_rec.coarse;
      A_REC_HI: rd_mux = DATA_W'({rd_rec.edge_rise, rd_rec.chan, rd_rec.fine});
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assert_ctrl_keep_R6: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == A_CTRL) |=> $stable(chan_en));
endmodule

// File: rtl/ts_ring_irq.sv
module ts_ring_irq
  import ts_ring_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int TMR_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evt_valid,
  input  logic [CHAN_W-1:0]   evt_chan,
  input  logic                evt_edge,
  input  logic [COARSE_W-1:0] evt_coarse,
  input  logic [FINE_W-1:0]   evt_fine,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq
);
  localparam int AW       = $clog2(DEPTH);
  localparam int PW       = AW + 1;
  localparam int CH_SLOTS = 1 << CHAN_W;

  logic [NUM_CH-1:0]   chan_en;
  logic [CH_SLOTS-1:0] chan_en_ext;
  logic                accept, ack, overflow;
  logic [PW-1:0]       thresh, pending;
  logic [TMR_W-1:0]    tlimit;
  logic [AW-1:0]       wr_ptr, rd_idx;
  logic [1:0]          cause;
  ts_rec_t             new_rec, rd_rec;

  always_comb begin
    chan_en_ext             = '0;
    chan_en_ext[NUM_CH-1:0] = chan_en;
    accept                  = evt_valid && chan_en_ext[evt_chan];
    new_rec.edge_rise       = evt_edge;
    new_rec.chan            = evt_chan;
    new_rec.fine            = evt_fine;
    new_rec.coarse          = evt_coarse;
  end

  ts_ring_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .wr_en(accept), .wr_rec(new_rec),
    .rd_idx(rd_idx), .rd_rec(rd_rec), .wr_ptr(wr_ptr)
  );

  ts_irq_ctrl #(.DEPTH(DEPTH), .TMR_W(TMR_W), .PW(PW)) u_irq (
    .clk(clk), .rst(rst), .rec_in(accept), .ack(ack),
    .thresh(thresh), .tlimit(tlimit), .irq(irq),
    .pending(pending), .overflow(overflow), .cause(cause)
  );

  ts_host_regs #(.AW(AW), .PW(PW), .TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wr_ptr(wr_ptr), .pending(pending),
    .overflow(overflow), .irq(irq), .cause(cause), .rd_rec(rd_rec),
    .chan_en(chan_en), .thresh(thresh), .tlimit(tlimit), .ack(ack),
    .rd_idx(rd_idx), .reg_rdata(reg_rdata)
  );

  // R6 and R1: disabled or out-of-range channel leaves pointer alone
  assert_mask_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !chan_en_ext[evt_chan]) |=> $stable(wr_ptr));

  assert_bad_chan_R1: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_chan >= CHAN_W'(NUM_CH)) |=> $stable(wr_ptr));
endmodule

// File: tb/ts_ring_irq_tb.sv
module ts_ring_irq_tb;
  import ts_ring_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_chan = '0;
  logic        evt_edge = 1'b0;
  logic [31:0] evt_coarse = '0;
  logic [11:0] evt_fine = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [7:0]  exp_ptr = '0;
  logic [31:0] rv;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  ts_ring_irq u_dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_chan(evt_chan),
    .evt_edge(evt_edge), .evt_coarse(evt_coarse), .evt_fine(evt_fine),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic send(input logic [2:0] ch, input logic e, input logic [31:0] c,
                      input logic [11:0] f);
    evt_valid = 1'b1; evt_chan = ch; evt_edge = e; evt_coarse = c; evt_fine = f;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic read_rec(input logic [7:0] idx, output logic [31:0] lo,
                          output logic [31:0] hi);
    wr(A_INDEX, {24'b0, idx});
    @(negedge clk);
    rd(A_REC_LO, lo);
    rd(A_REC_HI, hi);
  endtask

  function automatic logic [31:0] hi_word(input logic e, input logic [2:0] ch,
                                          input logic [11:0] f);
    return {16'b0, e, ch, f};
  endfunction

  function automatic logic [31:0] st_word(input logic [7:0] p, input logic ov,
                                          input logic iq, input logic cc, input logic ct);
    return {20'b0, ct, cc, iq, ov, p};
  endfunction

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lo, hi;
    logic [7:0]  p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state (R12, R6, R10)
    rd(A_STATUS, rv); check("R12 reset status", rv, 32'h0);
    rd(A_PEND, rv);   check("R12 reset pending", rv, 32'h0);
    rd(A_CTRL, rv);   check("R6 reset mask", rv, 32'h1f);
    check("R10 reset irq", {31'b0, irq}, 32'h0);

    // basic storage with sources disabled (R1, R2, R12, R10)
    send(3'd0, 1'b1, 32'hAAAA_0001, 12'h123); exp_ptr++;
    send(3'd2, 1'b0, 32'hAAAA_0002, 12'hFED); exp_ptr++;
    send(3'd4, 1'b1, 32'hAAAA_0003, 12'h800); exp_ptr++;
    rd(A_STATUS, rv); check("R3 ptr after three", rv, st_word(exp_ptr, 0, 0, 0, 0));
    rd(A_PEND, rv);   check("R12 pending three", rv, 32'd3);
    check("R10 no irq when both zero", {31'b0, irq}, 32'h0);
    read_rec(8'd0, lo, hi);
    check("R2 rec0 coarse", lo, 32'hAAAA_0001);
    check("R2 rec0 hi", hi, hi_word(1, 0, 12'h123));
    read_rec(8'd1, lo, hi);
    check("R2 rec1 falling edge", hi, hi_word(0, 2, 12'hFED));
    read_rec(8'd2, lo, hi);
    check("R1 rec2 chan4", hi, hi_word(1, 4, 12'h800));
    check("R12 rec2 coarse", lo, 32'hAAAA_0003);

    // masking (R6) and invalid codes (R1)
    wr(A_CTRL, 32'h05);
    send(3'd1, 1'b1, 32'h1, 12'h1);
    send(3'd3, 1'b0, 32'h2, 12'h2);
    rd(A_STATUS, rv); check("R6 disabled channels dropped", rv[7:0], {24'b0, exp_ptr});
    rd(A_PEND, rv);   check("R6 pending unchanged", rv, 32'd3);
    send(3'd2, 1'b1, 32'hBBBB_0000, 12'h0AB); exp_ptr++;
    rd(A_STATUS, rv); check("R6 enabled channel stored", rv[7:0], {24'b0, exp_ptr});
    wr(A_CTRL, 32'h1f);
    send(3'd5, 1'b1, 32'h5, 12'h5);
    send(3'd6, 1'b0, 32'h6, 12'h6);
    send(3'd7, 1'b1, 32'h7, 12'h7);
    rd(A_STATUS, rv); check("R1 codes 5-7 dropped ptr", rv[7:0], {24'b0, exp_ptr});
    rd(A_PEND, rv);   check("R1 codes 5-7 dropped pending", rv, 32'd4);

    // ack (R8)
    wr(A_ACK, 32'h0);
    rd(A_PEND, rv); check("R8 ack clears pending", rv, 32'd0);

    // count threshold (R4, R11)
    wr(A_THRESH, 32'd4);
    for (int i = 0; i < 3; i++) begin
      send(3'(i), i[0], 32'h100 + 32'(i), 12'(i)); exp_ptr++;
    end
    check("R4 below threshold", {31'b0, irq}, 32'h0);
    send(3'd3, 1'b1, 32'h103, 12'h3); exp_ptr++;
    check("R4 irq not yet on count edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R4 irq one edge later", {31'b0, irq}, 32'h1);
    rd(A_STATUS, rv); check("R11 count cause", rv, st_word(exp_ptr, 0, 1, 1, 0));

    // ack with same-cycle record (R8)
    reg_wr = 1'b1; reg_addr = A_ACK; reg_wdata = '0;
    evt_valid = 1'b1; evt_chan = 3'd1; evt_edge = 1'b0; evt_coarse = 32'h200; evt_fine = 12'h0;
    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0; exp_ptr++;
    check("R8 irq cleared", {31'b0, irq}, 32'h0);
    rd(A_PEND, rv); check("R8 same-cycle record counted", rv, 32'd1);
    rd(A_STATUS, rv); check("R8 cause cleared", rv, st_word(exp_ptr, 0, 0, 0, 0));

    // time limit (R5, R11)
    wr(A_THRESH, 32'd0);
    wr(A_ACK, 32'h0);
    wr(A_TLIMIT, 32'd10);
    send(3'd2, 1'b1, 32'h300, 12'h1); exp_ptr++;
    repeat (10) @(negedge clk);
    check("R5 irq not before T+1", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R5 irq at T+1", {31'b0, irq}, 32'h1);
    rd(A_STATUS, rv); check("R11 time cause", rv, st_word(exp_ptr, 0, 1, 0, 1));

    // both sources: count first, then time first (R11)
    wr(A_THRESH, 32'd3);
    wr(A_TLIMIT, 32'd50);
    wr(A_ACK, 32'h0);
    evt_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      evt_chan = 3'(i); evt_edge = 1'b1; evt_coarse = 32'h400 + 32'(i); evt_fine = 12'h0;
      @(negedge clk); exp_ptr++;
    end
    evt_valid = 1'b0;
    @(negedge clk);
    check("R4 burst irq", {31'b0, irq}, 32'h1);
    rd(A_STATUS, rv); check("R11 count fired first", rv, st_word(exp_ptr, 0, 1, 1, 0));
    wr(A_ACK, 32'h0);
    send(3'd4, 1'b0, 32'h500, 12'h0); exp_ptr++;
    repeat (60) @(negedge clk);
    rd(A_STATUS, rv); check("R11 time fired first", rv, st_word(exp_ptr, 0, 1, 0, 1));

    // sustained burst, wrap and overwrite (R3, R7, R9)
    wr(A_THRESH, 32'd0);
    wr(A_TLIMIT, 32'd0);
    wr(A_ACK, 32'h0);
    rd(A_STATUS, rv); check("R9 no overflow before burst", rv[8], 32'h0);
    p0 = exp_ptr;
    evt_valid = 1'b1;
    for (int i = 0; i < 300; i++) begin
      evt_chan = 3'(i % 5); evt_edge = i[0];
      evt_coarse = 32'h1000_0000 + 32'(i); evt_fine = 12'((i * 7) & 32'hfff);
      @(negedge clk);
    end
    evt_valid = 1'b0;
    exp_ptr = 8'(p0 + 300);
    rd(A_STATUS, rv); check("R7 ptr after 300 back-to-back", rv[7:0], {24'b0, exp_ptr});
    check("R9 overflow set", rv[8], 32'h1);
    rd(A_PEND, rv); check("R9 pending saturates", rv, 32'd256);
    for (int j = 0; j < 256; j++) begin
      int i0;
      i0 = (j - int'(p0) + 256) % 256;
      if (i0 + 256 < 300) i0 = i0 + 256;
      read_rec(8'(j), lo, hi);
      check("R3 slot coarse", lo, 32'h1000_0000 + 32'(i0));
      check("R3 slot hi", hi, hi_word(i0[0], 3'(i0 % 5), 12'((i0 * 7) & 32'hfff)));
    end
    wr(A_ACK, 32'h0);
    rd(A_STATUS, rv); check("R9 overflow sticky after ack", rv[8], 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule